// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, from the destination MAC address at the head of an incoming Ethernet frame, whether the frame is to be kept. It takes the frame as a byte stream. A qualifier marks each valid byte and a second marker flags the first byte of each frame. Once the sixth destination byte has arrived, it raises a one-cycle strobe that carries the accept level. Frame storage, whole-frame CRC checking and software register access are handled elsewhere. The filter only sees the address bytes, three mode inputs, the 48-bit station address and a 64-bin multicast hash table that it holds itself.

The filter classifies every address while it arrives. The classes are all-ones broadcast, group (multicast) and individual (unicast). Alongside this it folds each byte into a CRC-32 whose top six bits select a multicast hash bin. One byte is handled per clock, so all state is final right after the sixth byte. The verdict is a Moore output of the decide state.

The controller has four states:
- `ST_IDLE`: after reset, waiting for a first byte.
- `ST_GATHER`: collecting bytes 2 to 6.
- `ST_DECIDE`: the single strobe cycle.
- `ST_DRAIN`: ignoring the rest of the frame.

Its transitions are:
- *start*: a first-marked valid byte in any state goes to `ST_GATHER`.
- *restart*: a first-marked byte inside `ST_GATHER` stays in `ST_GATHER` with the count reset.
- *complete*: the sixth byte in `ST_GATHER` goes to `ST_DECIDE`.
- *retire*: `ST_DECIDE` goes to `ST_DRAIN` when no new frame starts.
- *hold*: every other case leaves the state unchanged.

Top module: `rx_addr_filter`

## Requirements
- R1: When `mode_promisc` (bit 4 of the receive configuration byte) is high in the strobe cycle, the frame is accepted whatever its address.
- R2: A destination of six 0xFF bytes is broadcast. With promiscuous mode off, it is accepted exactly when `mode_bcast` (configuration bit 2) is high, and it is never treated as multicast.
- R3: A non-broadcast destination whose first byte has bit 0 set is multicast. With promiscuous mode off, it is rejected while `mode_mcast` (configuration bit 3) is low.
- R4: The hash for a multicast destination with `mode_mcast` high works as follows. A CRC-32 uses polynomial 0x04C11DB7 and starts from all ones. It is fed the six bytes in arrival order, each byte least significant bit first, with no final inversion. The hash index is CRC bits 31:26. The frame is accepted only if bit (index mod 8) of table byte (index / 8) is set.
- R5: Any other destination is accepted only when all six bytes equal `station_addr`. The first received byte is compared with bits 7:0 and byte k with bits 8k+7:8k.
- R6: The table is eight bytes. A pulse on `hash_we` writes `hash_wdata` into byte `hash_sel` only, effective from the next cycle, and leaves the other seven bytes unchanged.
- R7: `decision_valid` is high for exactly one cycle, the cycle after the sixth address byte is accepted. `accept` is low whenever `decision_valid` is low.
- R8: Valid bytes after the sixth, and not marked first, are ignored and cause no further strobe.
- R9: A byte with `byte_first` high starts a new address in any state. This includes the middle of an unfinished address, which is then abandoned without a strobe.
- R10: After reset, `decision_valid` and `accept` are low and every table bit is clear.
- R11: Cycles with `byte_valid` low are ignored, so address bytes may arrive with idle cycles between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | `byte_data` holds a frame byte this cycle |
| byte_first | input | 1 | The valid byte is the first byte of a frame |
| byte_data | input | 8 | Frame byte |
| mode_promisc | input | 1 | Accept all frames (configuration bit 4) |
| mode_bcast | input | 1 | Accept broadcast (configuration bit 2) |
| mode_mcast | input | 1 | Accept hashed multicast (configuration bit 3) |
| station_addr | input | 48 | Own address, first wire byte in bits 7:0 |
| hash_we | input | 1 | Hash table byte write strobe |
| hash_sel | input | 3 | Hash table byte selector |
| hash_wdata | input | 8 | Hash table byte write data |
| decision_valid | output | 1 | One-cycle verdict strobe |
| accept | output | 1 | Frame accepted, valid with the strobe |

## Verification
The multicast cases use a hash index that the bench computes on its own from the address. One test sets only that bin and expects acceptance. Another uses an address whose bin lies in a different table byte and expects rejection. A design with a reflected CRC, the wrong index bits or a swapped byte and bit split would accept or reject the wrong one.

The remaining corner cases each target a specific fault:
- Broadcast with only multicast enabled: a design that checks for a group address before broadcast would wrongly accept it.
- Unicast addresses that differ in only the first or only the last byte: these expose a comparison that misses an end byte.
- Restarted addresses and trailing bytes: a design that fails to reset its count would strobe early, and one that fails to drain would strobe twice.
- Gaps between bytes: a design that counts cycles instead of bytes would strobe early.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_DECIDE = 2'd2,
        ST_DRAIN  = 2'd3
    } rxf_state_e;

    localparam int unsigned CRC_WIDTH  = 32;
    localparam logic [CRC_WIDTH-1:0] CRC_INIT = '1;
    localparam logic [7:0] BCAST_BYTE = 8'hFF;
endpackage

// File: rtl/rxf_crc32.sv
module rxf_crc32 #(
    parameter int unsigned HASH_BITS = 6,
    parameter logic [31:0] POLY      = 32'h04C11DB7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 first,
    input  logic [7:0]           din,
    output logic [HASH_BITS-1:0] hash_idx
);
    import rxf_pkg::*;

    logic [CRC_WIDTH-1:0] crc_q;
    logic [CRC_WIDTH-1:0] crc_d;

    // Fold one byte, least significant bit first, into the running value.
    always_comb begin
        logic [CRC_WIDTH-1:0] acc;
        acc = first ? CRC_INIT : crc_q;
        for (int b = 0; b < 8; b++) begin
            if (acc[CRC_WIDTH-1] ^ din[b]) begin
                acc = {acc[CRC_WIDTH-2:0], 1'b0} ^ POLY;
            end else begin
                acc = {acc[CRC_WIDTH-2:0], 1'b0};
            end
        end
        crc_d = acc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_INIT;
        end else if (en) begin
            crc_q <= crc_d;
        end
    end

    assign hash_idx = crc_q[CRC_WIDTH-1 -: HASH_BITS];
endmodule

// File: rtl/rxf_hash_table.sv
module rxf_hash_table #(
    parameter int unsigned HASH_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [HASH_BITS-4:0] sel,
    input  logic [7:0]           wdata,
    input  logic [HASH_BITS-1:0] lookup_idx,
    output logic                 hit
);
    localparam int unsigned N_BINS  = 2 ** HASH_BITS;
    localparam int unsigned N_BYTES = N_BINS / 8;

    logic [N_BINS-1:0] bins_flat;

    for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (we && (sel == g[HASH_BITS-4:0])) begin
                byte_q <= wdata;
            end
        end
        assign bins_flat[g*8 +: 8] = byte_q;
    end

    // Bin index = byte*8 + bit, so the flat vector is indexed directly.
    assign hit = bins_flat[lookup_idx];
endmodule

// File: rtl/rxf_addr_match.sv
module rxf_addr_match #(
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned CNT_W      = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    first,
    input  logic [CNT_W-1:0]        pos,
    input  logic [7:0]              din,
    input  logic [8*ADDR_BYTES-1:0] station,
    output logic                    own_match,
    output logic                    all_ones,
    output logic                    group_bit
);
    import rxf_pkg::*;

    logic [7:0] ref_byte;
    logic       byte_eq;
    logic       byte_ff;

    assign ref_byte = station[pos*8 +: 8];
    assign byte_eq  = (din == ref_byte);
    assign byte_ff  = (din == BCAST_BYTE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_match <= 1'b0;
            all_ones  <= 1'b0;
            group_bit <= 1'b0;
        end else if (en) begin
            if (first) begin
                own_match <= byte_eq;
                all_ones  <= byte_ff;
                group_bit <= din[0];
            end else begin
                own_match <= own_match & byte_eq;
                all_ones  <= all_ones & byte_ff;
            end
        end
    end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
    parameter int unsigned ADDR_BYTES = 6,
    parameter int unsigned HASH_BITS  = 6,
    parameter logic [31:0] CRC_POLY   = 32'h04C11DB7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        byte_valid,
    input  logic                        byte_first,
    input  logic [7:0]                  byte_data,
    input  logic                        mode_promisc,
    input  logic                        mode_bcast,
    input  logic                        mode_mcast,
    input  logic [8*ADDR_BYTES-1:0]     station_addr,
    input  logic                        hash_we,
    input  logic [HASH_BITS-4:0]        hash_sel,
    input  logic [7:0]                  hash_wdata,
    output logic                        decision_valid,
    output logic                        accept
);
    import rxf_pkg::*;

    localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(ADDR_BYTES - 1);

    rxf_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             take_byte;
    logic [CNT_W-1:0] pos;
    logic [HASH_BITS-1:0] hash_idx;
    logic             bin_hit;
    logic             own_match, all_ones, group_bit;
    logic             verdict;

    assign take_byte = byte_valid && (byte_first || state_q == ST_GATHER);
    assign pos       = byte_first ? '0 : cnt_q;

    rxf_crc32 #(.HASH_BITS(HASH_BITS), .POLY(CRC_POLY)) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (take_byte),
        .first    (byte_first),
        .din      (byte_data),
        .hash_idx (hash_idx)
    );

    rxf_hash_table #(.HASH_BITS(HASH_BITS)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (hash_we),
        .sel        (hash_sel),
        .wdata      (hash_wdata),
        .lookup_idx (hash_idx),
        .hit        (bin_hit)
    );

    rxf_addr_match #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (take_byte),
        .first     (byte_first),
        .pos       (pos),
        .din       (byte_data),
        .station   (station_addr),
        .own_match (own_match),
        .all_ones  (all_ones),
        .group_bit (group_bit)
    );

    // Next-state and byte count.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (byte_valid && byte_first) begin
            cnt_d   = CNT_W'(1);
            state_d = (ADDR_BYTES == 1) ? ST_DECIDE : ST_GATHER;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_GATHER: begin
                    if (byte_valid) begin
                        cnt_d = cnt_q + CNT_W'(1);
                        if (cnt_q == LAST_POS) begin
                            state_d = ST_DECIDE;
                        end
                    end
                end
                ST_DECIDE: state_d = ST_DRAIN;
                ST_DRAIN:  state_d = ST_DRAIN;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Priority: promiscuous, broadcast, multicast hash, own address.
    always_comb begin
        if (mode_promisc) begin
            verdict = 1'b1;
        end else if (all_ones) begin
            verdict = mode_bcast;
        end else if (group_bit) begin
            verdict = mode_mcast && bin_hit;
        end else begin
            verdict = own_match;
        end
    end

    // Outputs.
    always_comb begin
        decision_valid = 1'b0;
        accept         = 1'b0;
        unique case (state_q)
            ST_DECIDE: begin
                decision_valid = 1'b1;
                accept         = verdict;
            end
            ST_IDLE, ST_GATHER, ST_DRAIN: begin
                decision_valid = 1'b0;
                accept         = 1'b0;
            end
            default: begin
                decision_valid = 1'b0;
                accept         = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
    parameter int unsigned ADDR_BYTES = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_valid,
    input logic       byte_first,
    input logic [7:0] byte_data,
    input logic       mode_promisc,
    input logic       mode_bcast,
    input logic       decision_valid,
    input logic       accept
);
    localparam int unsigned CW = $clog2(ADDR_BYTES + 1);

    logic [CW-1:0] seen_q;
    logic          ff_q;

    // Shadow of how many address bytes of the current frame have arrived.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
            ff_q   <= 1'b0;
        end else if (byte_valid && byte_first) begin
            seen_q <= CW'(1);
            ff_q   <= (byte_data == 8'hFF);
        end else if (byte_valid && seen_q != '0 && seen_q < CW'(ADDR_BYTES)) begin
            seen_q <= seen_q + CW'(1);
            ff_q   <= ff_q & (byte_data == 8'hFF);
        end
    end

    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid |=> !decision_valid);

    a_r7_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid |-> ($past(byte_valid) && seen_q == CW'(ADDR_BYTES)));

    a_r7_accept_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        !decision_valid |-> !accept);

    a_r1_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (decision_valid && mode_promisc) |-> accept);

    a_r2_broadcast_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (decision_valid && ff_q && !mode_promisc) |-> (accept == mode_bcast));
endmodule

bind rx_addr_filter rxf_checker #(.ADDR_BYTES(ADDR_BYTES)) u_rxf_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .byte_valid     (byte_valid),
    .byte_first     (byte_first),
    .byte_data      (byte_data),
    .mode_promisc   (mode_promisc),
    .mode_bcast     (mode_bcast),
    .decision_valid (decision_valid),
    .accept         (accept)
);

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic        byte_first = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        mode_promisc = 1'b0;
    logic        mode_bcast = 1'b0;
    logic        mode_mcast = 1'b0;
    logic [47:0] station_addr = 48'h6655_4433_2202;
    logic        hash_we = 1'b0;
    logic [2:0]  hash_sel = '0;
    logic [7:0]  hash_wdata = '0;
    logic        decision_valid;
    logic        accept;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] MC_A  = 48'h0000_5E00_0001;

    always #10 clk = ~clk;

    rx_addr_filter i_rx_addr_filter (
        .clk, .rst_n, .byte_valid, .byte_first, .byte_data,
        .mode_promisc, .mode_bcast, .mode_mcast, .station_addr,
        .hash_we, .hash_sel, .hash_wdata, .decision_valid, .accept
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Spec model for R4: byte k of a is a[8k+7:8k], bits fed LSB first.
    function automatic logic [5:0] hidx(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int n = 0; n < 48; n++) begin
            logic fb = c[31] ^ a[n];
            c = c << 1;
            if (fb) c = c ^ 32'h04C11DB7;
        end
        return c[31:26];
    endfunction

    task automatic set_mode(input logic p, input logic b, input logic m);
        mode_promisc = p; mode_bcast = b; mode_mcast = m;
    endtask

    task automatic wr_table(input int sel, input logic [7:0] d);
        @(negedge clk);
        hash_we = 1'b1; hash_sel = sel[2:0]; hash_wdata = d;
        @(negedge clk);
        hash_we = 1'b0;
    endtask

    // Sends six address bytes; checks no early strobe, the verdict, and strobe width.
    task automatic send_addr(input string req, input logic [47:0] a,
                             input int gap, input logic exp);
        @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            byte_valid = 1'b1;
            byte_first = (k == 0);
            byte_data  = a[8*k +: 8];
            @(negedge clk);
            byte_valid = 1'b0;
            byte_first = 1'b0;
            if (k < 5) begin
                chk("R7 no early strobe", decision_valid, 1'b0);
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    chk("R11 idle cycle ignored", decision_valid, 1'b0);
                end
            end
        end
        chk({req, " strobe"}, decision_valid, 1'b1);
        chk({req, " verdict"}, accept, exp);
        @(negedge clk);
        chk("R7 one-cycle strobe", decision_valid, 1'b0);
        chk("R7 accept low off strobe", accept, 1'b0);
    endtask

    task automatic t_reset();
        chk("R10 strobe low after reset", decision_valid, 1'b0);
        chk("R10 accept low after reset", accept, 1'b0);
        set_mode(0, 0, 1);
        send_addr("R10 table empty rejects multicast", MC_A, 0, 1'b0);
    endtask

    task automatic t_promisc();
        set_mode(1, 0, 0);
        send_addr("R1 promisc foreign unicast", 48'h1111_2222_3344, 0, 1'b1);
        send_addr("R1 promisc broadcast", BCAST, 0, 1'b1);
    endtask

    task automatic t_bcast();
        set_mode(0, 1, 0);
        send_addr("R2 broadcast enabled", BCAST, 0, 1'b1);
        set_mode(0, 0, 0);
        send_addr("R2 broadcast disabled", BCAST, 0, 1'b0);
        set_mode(0, 0, 1);
        wr_table(0, 8'hFF); wr_table(1, 8'hFF); wr_table(2, 8'hFF); wr_table(3, 8'hFF);
        wr_table(4, 8'hFF); wr_table(5, 8'hFF); wr_table(6, 8'hFF); wr_table(7, 8'hFF);
        send_addr("R2 broadcast not treated as multicast", BCAST, 0, 1'b0);
        for (int s = 0; s < 8; s++) wr_table(s, 8'h00);
    endtask

    task automatic t_mcast();
        logic [5:0]  ia = hidx(MC_A);
        logic [47:0] mc_b = MC_A;
        for (int v = 0; v < 256; v++) begin
            logic [47:0] cand = {MC_A[47:16], v[7:0], MC_A[7:0]};
            if (hidx(cand)[5:3] != ia[5:3]) begin
                mc_b = cand;
                break;
            end
        end
        wr_table(int'(ia[5:3]), 8'(1 << ia[2:0]));
        set_mode(0, 0, 1);
        send_addr("R4 multicast bin set", MC_A, 0, 1'b1);
        send_addr("R6 other table byte untouched", mc_b, 0, 1'b0);
        set_mode(0, 0, 0);
        send_addr("R3 multicast disabled", MC_A, 0, 1'b0);
        set_mode(0, 0, 1);
        wr_table(int'(ia[5:3]), ~8'(1 << ia[2:0]));
        send_addr("R4 multicast bin cleared", MC_A, 0, 1'b0);
    endtask

    task automatic t_unicast();
        set_mode(0, 0, 0);
        send_addr("R5 own address", station_addr, 0, 1'b1);
        send_addr("R5 last byte differs", station_addr ^ 48'h0100_0000_0000, 0, 1'b0);
        send_addr("R5 first byte differs", station_addr ^ 48'h0000_0000_0004, 0, 1'b0);
    endtask

    task automatic t_gaps();
        set_mode(0, 0, 0);
        send_addr("R11 own address with gaps", station_addr, 2, 1'b1);
    endtask

    task automatic t_restart();
        set_mode(0, 0, 0);
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            byte_valid = 1'b1; byte_first = (k == 0); byte_data = 8'h13;
            @(negedge clk);
        end
        byte_valid = 1'b0; byte_first = 1'b0;
        chk("R9 abandoned address no strobe", decision_valid, 1'b0);
        send_addr("R9 restart then own address", station_addr, 0, 1'b1);
    endtask

    task automatic t_trailing();
        set_mode(1, 0, 0);
        send_addr("R8 frame head", 48'h0A0B_0C0D_0E10, 0, 1'b1);
        for (int k = 0; k < 10; k++) begin
            byte_valid = 1'b1; byte_first = 1'b0; byte_data = 8'(k);
            @(negedge clk);
            chk("R8 trailing byte ignored", decision_valid, 1'b0);
        end
        byte_valid = 1'b0;
        @(negedge clk);
        chk("R8 no strobe after trailing bytes", decision_valid, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_promisc();
        t_bcast();
        t_mcast();
        t_unicast();
        t_gaps();
        t_restart();
        t_trailing();
        done = 1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule